// File: doc/BRIEF.md
# Character I/O and Interrupt Unit

This unit sits beside a 16-bit accumulator core and handles byte-wide traffic with one input device and one output device. It holds a one-byte receive register with a ready flag and a one-byte transmit register with an empty flag. When the core is executing an I/O instruction, it decodes the six selector bits from the instruction, and from them it returns a skip request, an accumulator-load request with its byte, or updates to the flags and the interrupt-enable bit.

It also keeps an interrupt-pending bit. This bit is raised between instructions when interrupts are enabled and either device flag is up. While the bit is set, the unit asks the core to hold off its normal fetch, and it drives a three-step sequence of its own:

- Step 0 captures the program counter and clears the address register.
- Step 1 writes the captured counter to word 0 and clears the program counter.
- Step 2 increments the program counter to 1, clears the sequence counter, and drops both the pending bit and the enable bit.

The core supplies its sequence-counter value, an "I/O instruction now" strobe, the low accumulator byte and its program counter. The devices see a data/valid pair for input and a data/acknowledge pair for output. Reset is synchronous and active high.

Top module: `cio_unit`

## Requirements
- R1: After reset, in_ready is 0, out_ready is 1, irq_enabled is 0 and irq_pending is 0.
- R2: A dev_in_valid pulse while in_ready is 0 stores dev_in_data and sets in_ready at the next clock. While in_ready is 1, dev_in_valid is ignored and the stored byte is kept.
- R3: With io_exec high and io_sel[5] (input-byte command) set, acc_ld is 1 and acc_ld_data equals the stored input byte in the same cycle, and in_ready is 0 after the clock. With io_exec low, every io_sel bit is ignored.
- R4: With io_exec high and io_sel[4] (output-byte command) set, dev_out_data takes acc_lo and out_ready goes to 0 at the next clock. A dev_out_ack pulse sets out_ready again, and has no effect while out_ready is already 1.
- R5: skip_req is high in the io_exec cycle when io_sel[3] is set and in_ready is 1, or when io_sel[2] is set and out_ready is 1; otherwise it is 0.
- R6: io_sel[1] sets irq_enabled and io_sel[0] clears it at the next clock. If both bits are given together, the clear wins.
- R7: irq_pending rises at a clock where t_state is 3 or more, irq_enabled is 1 and in_ready or out_ready is 1. It does not rise while t_state is 0, 1 or 2, or while irq_enabled is 0.
- R8: While irq_pending is 1, fetch_hold is 1. At t_state 0, ar_clr is 1 and pc_cur is captured.
- R9: While irq_pending is 1 at t_state 1, the unit asserts mem_we, pc_clr, mem_addr = 0, and mem_wdata = the pc_cur captured at step 0, zero-extended.
- R10: While irq_pending is 1 at t_state 2, pc_inc and seq_clr are 1. After that clock, irq_pending and irq_enabled are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t_state | input | 4 | Core sequence-counter value |
| io_exec | input | 1 | Core is executing an I/O instruction this cycle |
| io_sel | input | 6 | Instruction bits 11..6: input, output, skip-in, skip-out, enable, disable |
| acc_lo | input | 8 | Low byte of the accumulator |
| pc_cur | input | 12 | Current program counter |
| dev_in_data | input | 8 | Byte from the input device |
| dev_in_valid | input | 1 | Input device delivers a byte |
| dev_out_data | output | 8 | Byte held for the output device |
| dev_out_ack | input | 1 | Output device has consumed the byte |
| in_ready | output | 1 | Input byte waiting |
| out_ready | output | 1 | Output register free |
| acc_ld | output | 1 | Load accumulator low byte |
| acc_ld_data | output | 8 | Byte for the accumulator load |
| skip_req | output | 1 | Skip the next instruction |
| irq_enabled | output | 1 | Interrupt enable state |
| irq_pending | output | 1 | Interrupt pending state |
| fetch_hold | output | 1 | Suppress the normal fetch steps |
| ar_clr | output | 1 | Clear the address register |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| pc_clr | output | 1 | Clear the program counter |
| pc_inc | output | 1 | Increment the program counter |
| seq_clr | output | 1 | Clear the sequence counter |

## Verification
Input bytes are delivered both while the ready flag is low and again while it is high. The second byte must not replace the first, and this shows up in the byte that the next input command returns.

Skip commands are tried with their flag both set and clear, and one is issued with io_exec low. This separates flag-gated skipping from a skip that is always or never asserted.

The pending bit is driven in four situations:
- with the sequence value inside the fetch window;
- with interrupts disabled;
- with both device flags low;
- with only the output flag up.

Each one isolates one term of the raise condition.

The service sequence changes pc_cur after step 0. This proves that the saved word comes from the step-0 capture and not from the live counter.

// File: rtl/cio_pkg.sv
package cio_pkg;
  // Positions of the command bits inside io_sel (instruction bits 11..6)
  localparam int unsigned SEL_INP = 5;
  localparam int unsigned SEL_OUT = 4;
  localparam int unsigned SEL_SKI = 3;
  localparam int unsigned SEL_SKO = 2;
  localparam int unsigned SEL_ION = 1;
  localparam int unsigned SEL_IOF = 0;
  localparam int unsigned SEL_COUNT = 6;

  // Interrupt service steps, numbered as sequence-counter values
  typedef enum logic [1:0] {
    SVC_SAVE  = 2'd0,
    SVC_WRITE = 2'd1,
    SVC_JUMP  = 2'd2
  } svc_step_e;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
  import cio_pkg::*;
#(
  parameter int unsigned SEL_W = SEL_COUNT
) (
  input  logic             io_exec,
  input  logic [SEL_W-1:0] io_sel,
  output logic [SEL_W-1:0] cmd
);
  // Each selector bit names one command; a command is live only during io_exec
  for (genvar i = 0; i < SEL_W; i++) begin : g_cmd
    assign cmd[i] = io_exec & io_sel[i];
  end
endmodule

// File: rtl/cio_flags.sv
module cio_flags #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] dev_in_data,
  input  logic              dev_in_valid,
  input  logic              dev_out_ack,
  input  logic              cmd_inp,
  input  logic              cmd_out,
  input  logic [CHAR_W-1:0] acc_lo,
  output logic [CHAR_W-1:0] in_reg,
  output logic              in_flag,
  output logic [CHAR_W-1:0] out_reg,
  output logic              out_flag
);
  logic in_accept;
  logic out_accept;

  assign in_accept  = dev_in_valid & ~in_flag;
  assign out_accept = dev_out_ack & ~out_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_reg  <= '0;
      in_flag <= 1'b0;
    end else if (in_accept) begin
      in_reg  <= dev_in_data;
      in_flag <= 1'b1;
    end else if (cmd_inp) begin
      in_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_reg  <= '0;
      out_flag <= 1'b1;
    end else if (cmd_out) begin
      out_reg  <= acc_lo;
      out_flag <= 1'b0;
    end else if (out_accept) begin
      out_flag <= 1'b1;
    end
  end

  // R2
  in_cap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_flag) |-> (in_reg == $past(dev_in_data)));

  // R2
  in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_flag && $past(in_flag)) |-> $stable(in_reg));

  // R4
  out_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_flag) |-> $past(cmd_out));
endmodule

// File: rtl/cio_irq.sv
module cio_irq
  import cio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned T_W       = 4,
  parameter int unsigned SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [T_W-1:0]    t_state,
  input  logic              cmd_ion,
  input  logic              cmd_iof,
  input  logic              any_flag,
  input  logic [ADDR_W-1:0] pc_cur,
  output logic              ien,
  output logic              r_pend,
  output logic              fetch_hold,
  output logic              ar_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pc_clr,
  output logic              pc_inc,
  output logic              seq_clr
);
  localparam logic [T_W-1:0] T_LAST_FETCH = T_W'(SVC_JUMP);
  localparam int unsigned    PAD_W        = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] saved_pc;
  logic [2:0]        svc;
  logic              in_fetch;
  logic              raise;

  // One strobe per service step, indexed by the step value
  for (genvar s = 0; s < 3; s++) begin : g_step
    assign svc[s] = r_pend & (t_state == T_W'(s));
  end

  assign in_fetch = (t_state <= T_LAST_FETCH);
  assign raise    = ~in_fetch & ien & any_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_pend <= 1'b0;
    end else if (svc[SVC_JUMP]) begin
      r_pend <= 1'b0;
    end else if (raise) begin
      r_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= 1'b0;
    end else if (svc[SVC_JUMP] || cmd_iof) begin
      ien <= 1'b0;
    end else if (cmd_ion) begin
      ien <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_pc <= '0;
    end else if (svc[SVC_SAVE]) begin
      saved_pc <= pc_cur;
    end
  end

  assign fetch_hold = r_pend;
  assign ar_clr     = svc[SVC_SAVE];
  assign mem_we     = svc[SVC_WRITE];
  assign mem_addr   = ADDR_W'(SAVE_ADDR);
  assign mem_wdata  = {{PAD_W{1'b0}}, saved_pc};
  assign pc_clr     = svc[SVC_WRITE];
  assign pc_inc     = svc[SVC_JUMP];
  assign seq_clr    = svc[SVC_JUMP];

  // R7
  pend_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(r_pend) |-> ($past(ien) && ($past(t_state) > T_LAST_FETCH)));

  // R10
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(r_pend) |-> !ien);

  // R9
  save_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(ar_clr)) |-> (mem_wdata[ADDR_W-1:0] == $past(pc_cur)));
endmodule

// File: rtl/cio_unit.sv
module cio_unit
  import cio_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_W    = 4,
  parameter int unsigned SEL_W  = SEL_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [T_W-1:0]    t_state,
  input  logic              io_exec,
  input  logic [SEL_W-1:0]  io_sel,
  input  logic [CHAR_W-1:0] acc_lo,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [CHAR_W-1:0] dev_in_data,
  input  logic              dev_in_valid,
  output logic [CHAR_W-1:0] dev_out_data,
  input  logic              dev_out_ack,
  output logic              in_ready,
  output logic              out_ready,
  output logic              acc_ld,
  output logic [CHAR_W-1:0] acc_ld_data,
  output logic              skip_req,
  output logic              irq_enabled,
  output logic              irq_pending,
  output logic              fetch_hold,
  output logic              ar_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pc_clr,
  output logic              pc_inc,
  output logic              seq_clr
);
  logic [SEL_W-1:0]  cmd;
  logic [CHAR_W-1:0] in_reg;

  cio_decode #(.SEL_W(SEL_W)) u_dec (
    .io_exec (io_exec),
    .io_sel  (io_sel),
    .cmd     (cmd)
  );

  cio_flags #(.CHAR_W(CHAR_W)) u_flags (
    .clk          (clk),
    .rst          (rst),
    .dev_in_data  (dev_in_data),
    .dev_in_valid (dev_in_valid),
    .dev_out_ack  (dev_out_ack),
    .cmd_inp      (cmd[SEL_INP]),
    .cmd_out      (cmd[SEL_OUT]),
    .acc_lo       (acc_lo),
    .in_reg       (in_reg),
    .in_flag      (in_ready),
    .out_reg      (dev_out_data),
    .out_flag     (out_ready)
  );

  cio_irq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_W    (T_W)
  ) u_irq (
    .clk        (clk),
    .rst        (rst),
    .t_state    (t_state),
    .cmd_ion    (cmd[SEL_ION]),
    .cmd_iof    (cmd[SEL_IOF]),
    .any_flag   (in_ready | out_ready),
    .pc_cur     (pc_cur),
    .ien        (irq_enabled),
    .r_pend     (irq_pending),
    .fetch_hold (fetch_hold),
    .ar_clr     (ar_clr),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .pc_clr     (pc_clr),
    .pc_inc     (pc_inc),
    .seq_clr    (seq_clr)
  );

  assign acc_ld      = cmd[SEL_INP];
  assign acc_ld_data = in_reg;
  assign skip_req    = (cmd[SEL_SKI] & in_ready) | (cmd[SEL_SKO] & out_ready);

  // R3
  inp_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> $past(acc_ld));

  // R5
  skip_src_chk: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> (in_ready || out_ready));
endmodule

// File: tb/sim_cio_unit.sv
module sim_cio_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  t_state = '0;
  logic        io_exec = 1'b0;
  logic [5:0]  io_sel = '0;
  logic [7:0]  acc_lo = '0;
  logic [11:0] pc_cur = '0;
  logic [7:0]  dev_in_data = '0;
  logic        dev_in_valid = 1'b0;
  logic        dev_out_ack = 1'b0;
  logic [7:0]  dev_out_data;
  logic        in_ready, out_ready, acc_ld, skip_req, irq_enabled, irq_pending;
  logic [7:0]  acc_ld_data;
  logic        fetch_hold, ar_clr, mem_we, pc_clr, pc_inc, seq_clr;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;

  always #10 clk = ~clk;

  cio_unit u0 (
    .clk(clk), .rst(rst), .t_state(t_state), .io_exec(io_exec), .io_sel(io_sel),
    .acc_lo(acc_lo), .pc_cur(pc_cur), .dev_in_data(dev_in_data),
    .dev_in_valid(dev_in_valid), .dev_out_data(dev_out_data), .dev_out_ack(dev_out_ack),
    .in_ready(in_ready), .out_ready(out_ready), .acc_ld(acc_ld), .acc_ld_data(acc_ld_data),
    .skip_req(skip_req), .irq_enabled(irq_enabled), .irq_pending(irq_pending),
    .fetch_hold(fetch_hold), .ar_clr(ar_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_clr(pc_clr), .pc_inc(pc_inc), .seq_clr(seq_clr)
  );

  localparam int S_INRDY = 0, S_OUTRDY = 1, S_IEN = 2, S_PEND = 3, S_ACCLD = 4,
                 S_ACCD = 5, S_SKIP = 6, S_OUTD = 7, S_HOLD = 8, S_ARCLR = 9,
                 S_WE = 10, S_MADDR = 11, S_WDATA = 12, S_PCCLR = 13, S_PCINC = 14,
                 S_SEQCLR = 15;

  string rq[$];
  int    sq[$];
  int    eq[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  function automatic int observe(int sel);
    case (sel)
      S_INRDY:  return int'(in_ready);
      S_OUTRDY: return int'(out_ready);
      S_IEN:    return int'(irq_enabled);
      S_PEND:   return int'(irq_pending);
      S_ACCLD:  return int'(acc_ld);
      S_ACCD:   return int'(acc_ld_data);
      S_SKIP:   return int'(skip_req);
      S_OUTD:   return int'(dev_out_data);
      S_HOLD:   return int'(fetch_hold);
      S_ARCLR:  return int'(ar_clr);
      S_WE:     return int'(mem_we);
      S_MADDR:  return int'(mem_addr);
      S_WDATA:  return int'(mem_wdata);
      S_PCCLR:  return int'(pc_clr);
      S_PCINC:  return int'(pc_inc);
      S_SEQCLR: return int'(seq_clr);
      default:  return -1;
    endcase
  endfunction

  // Driver side: queue an expectation for the check of the current step
  task automatic expect_v(string req, int sel, int val);
    rq.push_back(req);
    sq.push_back(sel);
    eq.push_back(val);
  endtask

  // Begin a step: just after the falling edge, pulses return to idle
  task automatic step();
    @(negedge clk);
    #1;
    io_exec      = 1'b0;
    io_sel       = '0;
    dev_in_valid = 1'b0;
    dev_out_ack  = 1'b0;
  endtask

  task automatic io_cmd(logic [5:0] sel);
    io_exec = 1'b1;
    io_sel  = sel;
  endtask

  // Monitor: pops and compares everything queued for this step
  initial begin
    forever begin
      @(negedge clk);
      #8;
      while (sq.size() > 0) begin
        automatic string r = rq.pop_front();
        automatic int    s = sq.pop_front();
        automatic int    e = eq.pop_front();
        automatic int    g = observe(s);
        total++;
        if (g != e) begin
          bad++;
          $display("FAIL %s sig=%0d actual=%0h expected=%0h", r, s, g, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step();
    rst = 1'b0;
    // R1 reset state
    expect_v("R1", S_INRDY, 0);
    expect_v("R1", S_OUTRDY, 1);
    expect_v("R1", S_IEN, 0);
    expect_v("R1", S_PEND, 0);

    // R2 byte delivered while empty
    step(); dev_in_data = 8'hA5; dev_in_valid = 1'b1;
    expect_v("R2", S_INRDY, 0);
    step(); dev_in_data = 8'h3C; dev_in_valid = 1'b1;
    expect_v("R2", S_INRDY, 1);
    // R3 input command returns the first byte; R2 second delivery ignored
    step(); io_cmd(6'b100000);
    expect_v("R2", S_ACCD, 8'hA5);
    expect_v("R3", S_ACCLD, 1);
    step();
    expect_v("R3", S_INRDY, 0);
    expect_v("R3", S_ACCLD, 0);

    // R4 output command
    step(); acc_lo = 8'h5A; io_cmd(6'b010000);
    step();
    expect_v("R4", S_OUTRDY, 0);
    expect_v("R4", S_OUTD, 8'h5A);
    dev_out_ack = 1'b1;
    step();
    expect_v("R4", S_OUTRDY, 1);
    dev_out_ack = 1'b1;
    step();
    expect_v("R4", S_OUTRDY, 1);
    expect_v("R4", S_OUTD, 8'h5A);

    // R5 skip on input flag, flag clear then set
    step(); io_cmd(6'b001000);
    expect_v("R5", S_SKIP, 0);
    step(); dev_in_data = 8'h11; dev_in_valid = 1'b1;
    step(); io_cmd(6'b001000);
    expect_v("R5", S_SKIP, 1);
    // R3 selector ignored without io_exec
    step(); io_sel = 6'b101000;
    expect_v("R3", S_SKIP, 0);
    expect_v("R3", S_ACCLD, 0);
    step();
    expect_v("R3", S_INRDY, 1);
    // R5 skip on output flag, set then clear
    io_cmd(6'b000100);
    expect_v("R5", S_SKIP, 1);
    step(); acc_lo = 8'hC3; io_cmd(6'b010000);
    step(); io_cmd(6'b000100);
    expect_v("R5", S_SKIP, 0);

    // R6 enable, disable, both at once
    step(); io_cmd(6'b000010);
    step();
    expect_v("R6", S_IEN, 1);
    io_cmd(6'b000001);
    step();
    expect_v("R6", S_IEN, 0);
    io_cmd(6'b000010);
    step(); io_cmd(6'b000011);
    expect_v("R6", S_IEN, 1);
    step();
    expect_v("R6", S_IEN, 0);

    // R7 disabled: no pending even outside fetch with in flag up
    t_state = 4'd3;
    step();
    expect_v("R7", S_PEND, 0);
    t_state = 4'd0; io_cmd(6'b000010);
    step();
    expect_v("R6", S_IEN, 1);
    t_state = 4'd1;
    step();
    expect_v("R7", S_PEND, 0);
    t_state = 4'd4;
    step();
    expect_v("R7", S_PEND, 1);

    // R8 service step 0
    t_state = 4'd0; pc_cur = 12'h123;
    expect_v("R8", S_HOLD, 1);
    expect_v("R8", S_ARCLR, 1);
    expect_v("R8", S_WE, 0);
    // R9 service step 1 with a changed live counter
    step(); t_state = 4'd1; pc_cur = 12'h124;
    expect_v("R9", S_WE, 1);
    expect_v("R9", S_MADDR, 0);
    expect_v("R9", S_WDATA, 16'h0123);
    expect_v("R9", S_PCCLR, 1);
    expect_v("R9", S_ARCLR, 0);
    // R10 service step 2
    step(); t_state = 4'd2;
    expect_v("R10", S_PCINC, 1);
    expect_v("R10", S_SEQCLR, 1);
    expect_v("R10", S_PEND, 1);
    step(); t_state = 4'd0;
    expect_v("R10", S_PEND, 0);
    expect_v("R10", S_IEN, 0);
    expect_v("R10", S_HOLD, 0);
    expect_v("R8", S_ARCLR, 0);

    // R7 both flags low: no pending; then output flag alone raises it
    step(); io_cmd(6'b100000);
    step();
    expect_v("R3", S_INRDY, 0);
    expect_v("R4", S_OUTRDY, 0);
    io_cmd(6'b000010);
    step(); t_state = 4'd5;
    expect_v("R6", S_IEN, 1);
    step();
    expect_v("R7", S_PEND, 0);
    dev_out_ack = 1'b1; t_state = 4'd0;
    step(); t_state = 4'd5;
    expect_v("R4", S_OUTRDY, 1);
    step(); t_state = 4'd0;
    expect_v("R7", S_PEND, 1);

    step();
    step();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule